// File: doc/BRIEF.md
# Parallel EEPROM Page-Load and Program Controller

This block is the parallel-bus front end of a byte-wide EEPROM. A host drives a 15-bit address, active-low chip select, write enable and output enable, and reads bytes back on an 8-bit data output that has a separate output-enable flag. A system clock samples all bus inputs through two-flop synchronisers. Write strobes load bytes into a 64-entry page buffer. After the last load, the bus stays quiet for a programmable number of clocks. Then the block runs a self-timed program cycle. The cycle first copies every loaded byte, and only those, into the external array, and then stays busy for the rest of its programmed length.

The array is outside the block. The block presents the synchronised address on a read port and takes read data back combinationally. It issues single-byte writes on a separate write port. While the program cycle is busy, a host read does not return array data. It returns a polling word. Its MSB is the inverse of the MSB of the last byte loaded. The next bit inverts after each completed read. The low bits are zero. The byte-load timeout and the program length are parameters in system-clock cycles.

Top module: `eep_par_front`

## Requirements
- R1: A write strobe exists only while chip select and write enable are both low and output enable is high. Any other combination, including all three low, loads nothing.
- R2: The load address is taken when the write strobe becomes active, which is on the later of the two falling edges. The load data is the value held on the data input just before the strobe ends, which is on the earlier of the two rising edges. Changes on either input outside the strobe have no effect.
- R3: Address bits 14:6 select the page and bits 5:0 select the byte within it. One to 64 bytes may be loaded in any offset order, and all of them are programmed into that page.
- R4: The program cycle starts once TBLC_CYCLES clocks pass without an accepted load after the last one ended. Until then, reads return the unchanged array contents.
- R5: Only the bytes that were loaded are written to the array. Every other byte of the page keeps its old value.
- R6: During the program cycle, every read returns bit 7 equal to the inverse of bit 7 of the last byte loaded, and bits 5:0 equal to zero.
- R7: During the program cycle, bit 6 of the read data takes opposite values on two consecutive reads.
- R8: After PROG_CYCLES clocks the cycle ends, and reads return the true array data, including the newly written bytes.
- R9: After the first byte of a page load, a load whose bits 14:6 differ from the latched page is ignored.
- R10: Write strobes made while the program cycle is busy are ignored.
- R11: data_oe_o is high only when chip select and output enable are low and write enable is high, two clocks after those inputs are sampled. data_o is zero whenever data_oe_o is low.
- R12: While reset is asserted, data_oe_o and arr_wr_en_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 15 | Byte address from the host |
| data_i | input | 8 | Write data from the host |
| csn_i | input | 1 | Chip select, active low |
| wen_i | input | 1 | Write enable, active low |
| oen_i | input | 1 | Output enable, active low |
| data_o | output | 8 | Read data or polling word |
| data_oe_o | output | 1 | High when the host bus should be driven |
| arr_rd_addr_o | output | 15 | Array read address |
| arr_rd_data_i | input | 8 | Array read data, combinational from arr_rd_addr_o |
| arr_wr_en_o | output | 1 | Array single-byte write strobe |
| arr_wr_addr_o | output | 15 | Array write address |
| arr_wr_data_o | output | 8 | Array write data |

## Verification
Two functions can fall into the same clock. The first is the end of the byte-load window, which moves the block into its busy cycle. The second is either a new write strobe arriving or a host read being served. The bench writes to a different page once the window has expired and the cycle is busy. It then checks that the extra byte never reaches the array. It also reads during the window and after it closes, and judges each result by whether it returns old array data or the polling word. Reads that straddle the busy cycle are checked through the inverted MSB, the zero low bits and the alternating bit 6. The final array contents are then compared with a shadow model held in the bench.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } eep_state_e;
endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
  parameter int            W       = 1,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      q_o  <= RST_VAL;
    end else begin
      s1_q <= d_i;
      q_o  <= s1_q;
    end
  end
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
  parameter int PAGE_BYTES = 64,
  parameter int DATA_W     = 8,
  localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [OFF_W-1:0]  ld_off_i,
  input  logic [DATA_W-1:0] ld_data_i,
  input  logic              clr_i,
  input  logic [OFF_W-1:0]  rd_off_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_sel_o
);
  logic [DATA_W-1:0] byte_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask_q;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_byte
    logic hit;
    assign hit = ld_i && (ld_off_i == OFF_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        byte_q[g] <= '0;
        mask_q[g] <= 1'b0;
      end else begin
        if (hit) byte_q[g] <= ld_data_i;
        if (clr_i)    mask_q[g] <= 1'b0;
        else if (hit) mask_q[g] <= 1'b1;
      end
    end
  end

  assign rd_data_o = byte_q[rd_off_i];
  assign rd_sel_o  = mask_q[rd_off_i];
endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
  import eep_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int DATA_W      = 8,
  parameter int PAGE_BYTES  = 64,
  parameter int TBLC_CYCLES = 20000,
  parameter int PROG_CYCLES = 18000000,
  localparam int OFF_W      = $clog2(PAGE_BYTES),
  localparam int PG_W       = ADDR_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csn_s_i,
  input  logic              wen_s_i,
  input  logic              oen_s_i,
  input  logic [ADDR_W-1:0] addr_s_i,
  input  logic [DATA_W-1:0] data_s_i,
  output logic              ld_o,
  output logic [OFF_W-1:0]  ld_off_o,
  output logic [DATA_W-1:0] ld_data_o,
  output logic              clr_o,
  output logic [OFF_W-1:0]  cm_off_o,
  input  logic              cm_sel_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              busy_o,
  output logic              rd_act_o,
  output logic              tog_o,
  output logic              last_msb_o
);
  localparam int TW = $clog2(TBLC_CYCLES + 1);
  localparam int PW = $clog2(PROG_CYCLES + 1);

  eep_state_e      st_q;
  logic            wr_act, wr_act_q, rd_act, rd_act_q;
  logic            wr_start, wr_end, rd_end;
  logic            ok_q, page_hit, accept_start, commit, load_busy;
  logic [OFF_W-1:0]  off_q;
  logic [PG_W-1:0]   page_q;
  logic [DATA_W-1:0] hold_q;
  logic [TW-1:0]     tmr_q;
  logic [PW-1:0]     pcnt_q;
  logic              tog_q, last_msb_q;

  assign wr_act   = !csn_s_i && !wen_s_i && oen_s_i;
  assign rd_act   = !csn_s_i && !oen_s_i && wen_s_i;
  assign wr_start = wr_act && !wr_act_q;
  assign wr_end   = !wr_act && wr_act_q;
  assign rd_end   = !rd_act && rd_act_q;

  assign page_hit     = addr_s_i[ADDR_W-1:OFF_W] == page_q;
  assign accept_start = wr_start &&
                        ((st_q == ST_IDLE) || ((st_q == ST_LOAD) && page_hit));
  assign commit       = wr_end && ok_q && (st_q != ST_PROG);
  // an accepted strobe in flight keeps the load window open
  assign load_busy    = wr_act && (ok_q || accept_start);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_act_q <= 1'b0;
      rd_act_q <= 1'b0;
      hold_q   <= '0;
    end else begin
      wr_act_q <= wr_act;
      rd_act_q <= rd_act;
      if (wr_act) hold_q <= data_s_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ok_q   <= 1'b0;
      off_q  <= '0;
      page_q <= '0;
    end else if (wr_start) begin
      ok_q <= accept_start;
      if (accept_start) off_q <= addr_s_i[OFF_W-1:0];
      if (accept_start && st_q == ST_IDLE) page_q <= addr_s_i[ADDR_W-1:OFF_W];
    end else if (wr_end) begin
      ok_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      tmr_q      <= '0;
      pcnt_q     <= '0;
      tog_q      <= 1'b0;
      last_msb_q <= 1'b0;
    end else begin
      if (commit) last_msb_q <= hold_q[DATA_W-1];
      unique case (st_q)
        ST_IDLE: begin
          if (commit) begin
            st_q  <= ST_LOAD;
            tmr_q <= '0;
          end
        end
        ST_LOAD: begin
          if (commit || load_busy) begin
            tmr_q <= '0;
          end else if (tmr_q == TW'(TBLC_CYCLES - 1)) begin
            st_q   <= ST_PROG;
            pcnt_q <= '0;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        ST_PROG: begin
          if (rd_end) tog_q <= !tog_q;
          if (pcnt_q == PW'(PROG_CYCLES - 1)) begin
            st_q <= ST_IDLE;
          end else begin
            pcnt_q <= pcnt_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ld_o       = commit;
  assign ld_off_o   = off_q;
  assign ld_data_o  = hold_q;
  assign busy_o     = st_q == ST_PROG;
  assign clr_o      = busy_o && (pcnt_q == PW'(PROG_CYCLES - 1));
  assign cm_off_o   = pcnt_q[OFF_W-1:0];
  assign wr_en_o    = busy_o && (pcnt_q < PW'(PAGE_BYTES)) && cm_sel_i;
  assign wr_addr_o  = {page_q, cm_off_o};
  assign rd_act_o   = rd_act;
  assign tog_o      = tog_q;
  assign last_msb_o = last_msb_q;
endmodule

// File: rtl/eep_par_front.sv
module eep_par_front #(
  parameter int ADDR_W      = 15,
  parameter int DATA_W      = 8,
  parameter int PAGE_BYTES  = 64,
  parameter int TBLC_CYCLES = 20000,
  parameter int PROG_CYCLES = 18000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              csn_i,
  input  logic              wen_i,
  input  logic              oen_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic [ADDR_W-1:0] arr_rd_addr_o,
  input  logic [DATA_W-1:0] arr_rd_data_i,
  output logic              arr_wr_en_o,
  output logic [ADDR_W-1:0] arr_wr_addr_o,
  output logic [DATA_W-1:0] arr_wr_data_o
);
  localparam int OFF_W = $clog2(PAGE_BYTES);

  logic [2:0]        ctl_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] data_s;
  logic              ld, clr, cm_sel, busy_w, rd_act, tog, last_msb;
  logic [OFF_W-1:0]  ld_off, cm_off;
  logic [DATA_W-1:0] ld_data;

  eep_sync #(.W(3), .RST_VAL(3'b111)) u_sync_ctl (
    .clk_i, .rst_ni, .d_i({csn_i, wen_i, oen_i}), .q_o(ctl_s)
  );

  eep_sync #(.W(ADDR_W + DATA_W), .RST_VAL('0)) u_sync_bus (
    .clk_i, .rst_ni, .d_i({addr_i, data_i}), .q_o({addr_s, data_s})
  );

  eep_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES),
    .TBLC_CYCLES(TBLC_CYCLES), .PROG_CYCLES(PROG_CYCLES)
  ) u_ctrl (
    .clk_i, .rst_ni,
    .csn_s_i(ctl_s[2]), .wen_s_i(ctl_s[1]), .oen_s_i(ctl_s[0]),
    .addr_s_i(addr_s), .data_s_i(data_s),
    .ld_o(ld), .ld_off_o(ld_off), .ld_data_o(ld_data), .clr_o(clr),
    .cm_off_o(cm_off), .cm_sel_i(cm_sel),
    .wr_en_o(arr_wr_en_o), .wr_addr_o(arr_wr_addr_o),
    .busy_o(busy_w), .rd_act_o(rd_act), .tog_o(tog), .last_msb_o(last_msb)
  );

  eep_page_buf #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_buf (
    .clk_i, .rst_ni,
    .ld_i(ld), .ld_off_i(ld_off), .ld_data_i(ld_data), .clr_i(clr),
    .rd_off_i(cm_off), .rd_data_o(arr_wr_data_o), .rd_sel_o(cm_sel)
  );

  logic [DATA_W-1:0] poll_word;
  always_comb begin
    poll_word             = '0;
    poll_word[DATA_W-1]   = !last_msb;
    poll_word[DATA_W-2]   = tog;
  end

  assign arr_rd_addr_o = addr_s;
  assign data_oe_o     = rd_act;
  assign data_o        = !rd_act ? '0 : (busy_w ? poll_word : arr_rd_data_i);
endmodule

module eep_par_front_chk #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              csn_i,
  input logic              wen_i,
  input logic              oen_i,
  input logic [DATA_W-1:0] data_o,
  input logic              data_oe_o,
  input logic              arr_wr_en_o,
  input logic [ADDR_W-1:0] arr_wr_addr_o,
  input logic              busy_i
);
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 1'b1;
  end

  assert_oe_lag_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2) |-> (data_oe_o == $past(!csn_i && !oen_i && wen_i, 2)));

  assert_quiet_bus_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> (data_o == '0));

  assert_wr_only_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_wr_en_o |-> busy_i);

  assert_one_page_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_wr_en_o && $past(arr_wr_en_o) && $past(busy_i)) |->
      (arr_wr_addr_o[ADDR_W-1:6] == $past(arr_wr_addr_o[ADDR_W-1:6])));

  assert_poll_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && data_oe_o) |-> (data_o[5:0] == 6'd0));

  assert_done_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> !arr_wr_en_o);

  always_comb begin
    if (!rst_ni) assert_rst_quiet_R12: assert (!data_oe_o && !arr_wr_en_o);
  end
endmodule

bind eep_par_front eep_par_front_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .csn_i(csn_i), .wen_i(wen_i), .oen_i(oen_i),
  .data_o(data_o), .data_oe_o(data_oe_o), .arr_wr_en_o(arr_wr_en_o),
  .arr_wr_addr_o(arr_wr_addr_o), .busy_i(busy_w)
);

// File: tb/eep_par_front_tb.sv
`timescale 1ns/1ps
module eep_par_front_tb;
  localparam int TBLC = 40;
  localparam int PROG = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0]  din = '0;
  logic        csn = 1'b1, wen = 1'b1, oen = 1'b1;
  logic [7:0]  dout;
  logic        doe;
  logic [14:0] rd_addr, wr_addr;
  logic [7:0]  rd_data, wr_data;
  logic        wr_en;

  logic [7:0] mem [1024];
  logic [7:0] expv [1024];
  int checks = 0, fails = 0, cyc = 0;

  always #2.5 clk = !clk;

  eep_par_front #(.TBLC_CYCLES(TBLC), .PROG_CYCLES(PROG)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .data_i(din),
    .csn_i(csn), .wen_i(wen), .oen_i(oen),
    .data_o(dout), .data_oe_o(doe),
    .arr_rd_addr_o(rd_addr), .arr_rd_data_i(rd_data),
    .arr_wr_en_o(wr_en), .arr_wr_addr_o(wr_addr), .arr_wr_data_o(wr_data)
  );

  assign rd_data = mem[rd_addr[9:0]];
  always @(posedge clk) if (wr_en) mem[wr_addr[9:0]] <= wr_data;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp_v);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_we(logic [14:0] a, logic [7:0] d);
    addr = a; din = d; oen = 1'b1; csn = 1'b0;
    wait_n(1); wen = 1'b0;
    wait_n(4); wen = 1'b1;
    wait_n(1); csn = 1'b1;
    wait_n(3);
  endtask

  task automatic rd(logic [14:0] a, output logic [7:0] v, output logic oe);
    addr = a; wen = 1'b1; csn = 1'b0; oen = 1'b0;
    wait_n(5); v = dout; oe = doe;
    csn = 1'b1; oen = 1'b1;
    wait_n(4);
  endtask

  task automatic rd_chk(string req, logic [14:0] a);
    logic [7:0] v; logic oe;
    rd(a, v, oe);
    chk(req, {7'd0, oe}, 8'd1);
    chk(req, v, expv[a[9:0]]);
  endtask

  task automatic t_reset;
    chk("R12 oe", {7'd0, doe}, 8'd0);
    chk("R12 wr", {7'd0, wr_en}, 8'd0);
  endtask

  task automatic t_byte_write;
    logic [7:0] v1, v2; logic oe;
    wr_we(15'h045, 8'hA5);
    rd_chk("R4 before timeout", 15'h045);
    wait_n(TBLC + 15);
    rd(15'h045, v1, oe);
    chk("R6 poll msb", {7'd0, v1[7]}, 8'd0);
    chk("R6 poll low", {2'd0, v1[5:0]}, 8'd0);
    rd(15'h045, v2, oe);
    chk("R7 toggle", {7'd0, v2[6]}, {7'd0, !v1[6]});
    wait_n(PROG + 10);
    expv[10'h045] = 8'hA5;
    rd_chk("R8 new data", 15'h045);
    rd_chk("R5 neighbour", 15'h046);
  endtask

  task automatic t_page_any_order;
    logic [7:0] v; logic oe;
    wr_we(15'h08A, 8'h3C);
    wr_we(15'h083, 8'hC3);
    wr_we(15'h0BF, 8'h7E);
    wait_n(TBLC + 15);
    rd(15'h083, v, oe);
    chk("R6 poll msb of last", {7'd0, v[7]}, 8'd1);
    wait_n(PROG + 10);
    expv[10'h08A] = 8'h3C; expv[10'h083] = 8'hC3; expv[10'h0BF] = 8'h7E;
    rd_chk("R3 off 10", 15'h08A);
    rd_chk("R3 off 3", 15'h083);
    rd_chk("R3 off 63", 15'h0BF);
    rd_chk("R5 off 4", 15'h084);
    rd_chk("R5 off 0", 15'h080);
  endtask

  task automatic t_page_mismatch;
    wr_we(15'h0C1, 8'h11);
    wr_we(15'h101, 8'h22);
    wait_n(TBLC + PROG + 30);
    expv[10'h0C1] = 8'h11;
    rd_chk("R9 first page kept", 15'h0C1);
    rd_chk("R9 other page ignored", 15'h101);
  endtask

  task automatic t_busy_ignore;
    wr_we(15'h150, 8'h99);
    wait_n(TBLC + 15);
    wr_we(15'h1D1, 8'h77);
    wait_n(PROG + TBLC + 30);
    expv[10'h150] = 8'h99;
    rd_chk("R10 first write", 15'h150);
    rd_chk("R10 busy write ignored", 15'h1D1);
  endtask

  task automatic t_no_strobe;
    logic oe_seen;
    oe_seen = 1'b0;
    addr = 15'h1A0; din = 8'hEE;
    csn = 1'b0; wen = 1'b0; oen = 1'b0;
    repeat (8) begin
      wait_n(1);
      oe_seen = oe_seen | doe;
    end
    wen = 1'b1; oen = 1'b1;
    wait_n(1); csn = 1'b1;
    chk("R11 no drive with wen low", {7'd0, oe_seen}, 8'd0);
    wait_n(TBLC + PROG + 30);
    rd_chk("R1 all low no load", 15'h1A0);
    addr = 15'h1A0; csn = 1'b1; oen = 1'b0; wen = 1'b1;
    wait_n(5);
    chk("R11 csn high", {7'd0, doe}, 8'd0);
    chk("R11 data zero", dout, 8'd0);
    csn = 1'b0; oen = 1'b1;
    wait_n(5);
    chk("R11 oen high", {7'd0, doe}, 8'd0);
    csn = 1'b1;
    wait_n(3);
  endtask

  task automatic t_csn_ctrl;
    oen = 1'b1; csn = 1'b1; wen = 1'b0; addr = 15'h2FF; din = 8'h00;
    wait_n(3);
    addr = 15'h205; din = 8'h6B;
    wait_n(1); csn = 1'b0;
    wait_n(4); addr = 15'h2FF;
    wait_n(1); csn = 1'b1;
    wait_n(4); din = 8'hFF;
    wait_n(2); wen = 1'b1;
    wait_n(TBLC + PROG + 30);
    expv[10'h205] = 8'h6B;
    rd_chk("R2 csn-controlled load", 15'h205);
    rd_chk("R2 later address ignored", 15'h2FF);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin
      mem[i]  = 8'(i) ^ 8'h5A;
      expv[i] = 8'(i) ^ 8'h5A;
    end
    wait_n(3);
    t_reset;
    rst_n = 1'b1;
    wait_n(3);
    t_reset;
    t_byte_write;
    t_page_any_order;
    t_page_mismatch;
    t_busy_ignore;
    t_no_strobe;
    t_csn_ctrl;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule